// File: doc/BRIEF.md
# Asynchronous Serial Baud Clock Generator

This block derives the timing enables for one asynchronous serial channel. Three counters are chained. The first divides the system clock by 10 or 30. The second applies a further power-of-two divide chosen by a 3-bit speed code, or it takes its pulses from an external data clock. The third turns the resulting sampling enable into a bit enable at one sixteenth or one sixty-fourth of the sampling rate. Every counter runs in the system clock domain, and every output is a single-cycle enable pulse, so the serial engine never sees a derived clock.

Software writes one 8-bit control register. Its fields are prescale select (bit 0), speed/source code (bits 3:1), ratio select (bit 4) and parity sense (bit 5). Any write restarts every divider from zero, so the first period after a rate change is never shortened. The parity sense bit only drives the `parity_odd` output. Bit 0 of the read port shows the live clear-to-send input and not the stored prescale value. That same input also blocks the transmit-empty status it gates.

Top module: `baud_clkgen`

## Requirements
- R1: After reset the speed code reads back as 7 (bits 3:1 = 111). The ratio bit (bit 4) and the parity bit (bit 5) read 0, `parity_odd` is 0, and the prescale select is 0.
- R2: With the prescale select at 0, the system clock is divided by 10. With it at 1, the division is by 30.
- R3: Speed codes n = 0 to 6 add a further divide by 2^n. The interval between `samp_en` pulses is then prescale × 2^n cycles.
- R4: The ratio bit at 0 gives one `bit_en` per 16 `samp_en` pulses, and at 1 one per 64. The `bit_en` interval is therefore prescale × 2^n × ratio cycles.
- R5: Speed code 7 selects `ext_clk`. After synchronisation, each rising edge of `ext_clk` gives exactly one `samp_en` pulse, whatever the prescale select is set to.
- R6: A write (`wr_en` high at a clock edge) restarts all dividers. In internal modes, the first `samp_en` and `bit_en` come exactly one full period after that edge. A pulse that was due in the write cycle is still emitted.
- R7: `parity_odd` follows bit 5 of the last write (0 means even, 1 means odd). It has no effect on any divider interval.
- R8: While `cts` is high, `tdre_out` is 0. While `cts` is low, `tdre_out` equals `tdre_in`.
- R9: `rd_data[0]` shows the live `cts` input. `rd_data[5:1]` return the stored speed, ratio and parity fields, and `rd_data[7:6]` read 0.
- R10: `samp_en` and `bit_en` are single-cycle pulses, and `bit_en` is only ever high together with `samp_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| ext_clk | input | 1 | External data clock (asynchronous) |
| cts | input | 1 | Clear-to-send status input |
| tdre_in | input | 1 | Raw transmit-register-empty status |
| tdre_out | output | 1 | Transmit-empty status gated by clear-to-send |
| parity_odd | output | 1 | Stored parity sense for the serial engine |
| samp_en | output | 1 | Oversampling clock enable pulse |
| bit_en | output | 1 | Bit clock enable pulse |

## Verification
A register write and a due `bit_en` pulse can land in the same cycle. The bench provokes this by waiting at the falling edge for the predicted bit pulse and asserting `wr_en` in that very cycle. It then requires the pulse to be present, the new parity sense to appear, and the next `bit_en` to arrive exactly one new full period after the write edge. A behavioural cycle counter in the bench predicts both enables on every clock and judges each cycle against them.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int CTRL_W   = 8;
    localparam int CODE_W   = 3;
    localparam int PRE_LO   = 10;
    localparam int PRE_HI   = 30;
    localparam int RATIO_LO = 16;
    localparam int RATIO_HI = 64;
    localparam int SYNC_LEN = 2;

    localparam logic [CODE_W-1:0] CODE_EXT = '1;

    typedef struct packed {
        logic              odd;
        logic              ratio_hi;
        logic [CODE_W-1:0] speed;
        logic              pre_hi;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{odd: 1'b0, ratio_hi: 1'b0,
                                     speed: CODE_EXT, pre_hi: 1'b0};

    function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] d);
        ctrl_t c;
        c.pre_hi   = d[0];
        c.speed    = d[CODE_W:1];
        c.ratio_hi = d[CODE_W+1];
        c.odd      = d[CODE_W+2];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] pack_read(input ctrl_t c, input logic live_cts);
        logic [CTRL_W-1:0] r;
        r            = '0;
        r[0]         = live_cts;
        r[CODE_W:1]  = c.speed;
        r[CODE_W+1]  = c.ratio_hi;
        r[CODE_W+2]  = c.odd;
        return r;
    endfunction

endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
    parameter int LO = 10,
    parameter int HI = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic sel_hi,
    output logic tick
);
    localparam int W = $clog2(HI);

    logic [W-1:0] cnt_q;
    logic [W-1:0] limit;

    assign limit = sel_hi ? W'(HI - 1) : W'(LO - 1);
    assign tick  = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/baud_speed.sv
module baud_speed #(
    parameter int CODE_W = 3,
    parameter int SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    input  logic              pre_tick,
    input  logic              ext_clk,
    output logic              samp
);
    localparam int MAX_SHIFT = (1 << CODE_W) - 2;
    localparam int SW        = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;
    localparam logic [CODE_W-1:0] EXT_CODE = '1;

    logic [SW-1:0] cnt_q;
    logic [SW:0]   span;
    logic          int_tick;
    logic [SYNC-1:0] sync_q;
    logic          prev_q;
    logic          ext_rise;

    assign span     = ({{SW{1'b0}}, 1'b1} << code) - 1'b1;
    assign int_tick = pre_tick && (cnt_q == span[SW-1:0]);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (pre_tick) begin
            cnt_q <= int_tick ? '0 : cnt_q + 1'b1;
        end
    end

    generate
        if (SYNC == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= ext_clk;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC-2:0], ext_clk};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[SYNC-1];
    end

    assign ext_rise = sync_q[SYNC-1] && !prev_q;
    assign samp     = (code == EXT_CODE) ? ext_rise : int_tick;
endmodule

// File: rtl/baud_ratio.sv
module baud_ratio #(
    parameter int LO = 16,
    parameter int HI = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic sel_hi,
    input  logic samp_in,
    output logic bit_tick
);
    localparam int W = $clog2(HI);

    logic [W-1:0] cnt_q;
    logic [W-1:0] limit;

    assign limit    = sel_hi ? W'(HI - 1) : W'(LO - 1);
    assign bit_tick = samp_in && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (samp_in) begin
            cnt_q <= bit_tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
    import baud_pkg::*;
#(
    parameter int PRE_DIV_LO   = PRE_LO,
    parameter int PRE_DIV_HI   = PRE_HI,
    parameter int RAT_DIV_LO   = RATIO_LO,
    parameter int RAT_DIV_HI   = RATIO_HI,
    parameter int EXT_SYNC_LEN = SYNC_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              ext_clk,
    input  logic              cts,
    input  logic              tdre_in,
    output logic              tdre_out,
    output logic              parity_odd,
    output logic              samp_en,
    output logic              bit_en
);
    ctrl_t ctrl_q;
    logic  pre_tick;
    logic  samp_w;
    logic  bit_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_en) begin
            ctrl_q <= unpack_ctrl(wr_data);
        end
    end

    baud_prescale #(.LO(PRE_DIV_LO), .HI(PRE_DIV_HI)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (wr_en),
        .sel_hi  (ctrl_q.pre_hi),
        .tick    (pre_tick)
    );

    baud_speed #(.CODE_W(CODE_W), .SYNC(EXT_SYNC_LEN)) u_spd (
        .clk      (clk),
        .rst      (rst),
        .restart  (wr_en),
        .code     (ctrl_q.speed),
        .pre_tick (pre_tick),
        .ext_clk  (ext_clk),
        .samp     (samp_w)
    );

    baud_ratio #(.LO(RAT_DIV_LO), .HI(RAT_DIV_HI)) u_rat (
        .clk      (clk),
        .rst      (rst),
        .restart  (wr_en),
        .sel_hi   (ctrl_q.ratio_hi),
        .samp_in  (samp_w),
        .bit_tick (bit_w)
    );

    assign samp_en    = samp_w;
    assign bit_en     = bit_w;
    assign parity_odd = ctrl_q.odd;
    assign tdre_out   = tdre_in && !cts;
    assign rd_data    = pack_read(ctrl_q, cts);
endmodule

// File: rtl/baud_clkgen_chk.sv
module baud_clkgen_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       ext_clk,
    input logic       cts,
    input logic       tdre_in,
    input logic       tdre_out,
    input logic       parity_odd,
    input logic       samp_en,
    input logic       bit_en
);
    a_r1_reset_fields: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data[3:1] == 3'b111) && !rd_data[4] && !rd_data[5] && !parity_odd);

    a_r6_write_restart: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && ($past(wr_data[3:1]) != 3'b111)) |-> (!samp_en && !bit_en));

    a_r7_parity_follows: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) |-> (parity_odd == $past(wr_data[5])));

    a_r8_tdre_blocked: assert property (@(posedge clk) disable iff (rst)
        cts |-> !tdre_out);

    a_r10_bit_in_samp: assert property (@(posedge clk) disable iff (rst)
        bit_en |-> samp_en);

    a_r10_samp_single: assert property (@(posedge clk) disable iff (rst)
        samp_en |=> !samp_en);
endmodule

bind baud_clkgen baud_clkgen_chk u_chk (.*);

// File: tb/sim_baud_clkgen.sv
module sim_baud_clkgen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ext_clk = 1'b0;
    logic       cts = 1'b0;
    logic       tdre_in = 1'b0;
    logic       tdre_out;
    logic       parity_odd;
    logic       samp_en;
    logic       bit_en;

    int checks = 0;
    int fails  = 0;
    int cycle  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    baud_clkgen u0 (.*);

    // behavioural reference: cycles since last restart and active config
    int m_k = 1;
    int m_pre = 10;
    int m_code = 7;
    int m_rat = 16;

    always @(posedge clk) begin
        cycle <= cycle + 1;
        if (rst) begin
            m_k <= 1; m_pre <= 10; m_code <= 7; m_rat <= 16;
        end else if (wr_en) begin
            m_k    <= 1;
            m_pre  <= wr_data[0] ? 30 : 10;
            m_code <= int'(wr_data[3:1]);
            m_rat  <= wr_data[4] ? 64 : 16;
        end else begin
            m_k <= m_k + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-clock comparison in internal modes (R2 R3 R4 R10)
    always @(negedge clk) begin
        if (!rst && !done && m_code != 7) begin
            int sp;
            sp = m_pre * (1 << m_code);
            chk(samp_en == ((m_k % sp) == 0), "R3 per-cycle samp_en", int'(samp_en), int'((m_k % sp) == 0));
            chk(bit_en == ((m_k % (sp * m_rat)) == 0), "R4 per-cycle bit_en", int'(bit_en), int'((m_k % (sp * m_rat)) == 0));
        end
    end

    function automatic logic [7:0] cfg(int pre, int code, int rat, int odd);
        return {2'b00, odd[0], rat[0], code[2:0], pre[0]};
    endfunction

    // write in the current cycle; returns at the negedge of cycle 1 after the write edge
    task automatic do_write(input logic [7:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic first_pulse(input bit use_bit, input int exp, input string tag);
        int n = 1;
        while (!(use_bit ? bit_en : samp_en) && n < exp + 10) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic ext_run(input int edges, input int exp_samp, input int exp_bit, input string tag);
        int ns = 0;
        int nb = 0;
        for (int e = 0; e < edges; e++) begin
            ext_clk = 1'b1;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                if (samp_en) ns++;
                if (bit_en) nb++;
            end
            ext_clk = 1'b0;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                if (samp_en) ns++;
                if (bit_en) nb++;
            end
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (samp_en) ns++;
            if (bit_en) nb++;
        end
        chk(ns == exp_samp, {tag, " samp count"}, ns, exp_samp);
        chk(nb == exp_bit, {tag, " bit count"}, nb, exp_bit);
    endtask

    initial begin
        wait (cycle >= 190000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycle, 190000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(rd_data == 8'b0000_1110, "R1 reset read value", int'(rd_data), 8'h0e);
        chk(parity_odd == 1'b0, "R1 parity after reset", int'(parity_odd), 0);
        chk(samp_en == 1'b0 && bit_en == 1'b0, "R1 no pulses without ext edge", int'({samp_en, bit_en}), 0);

        // R8 / R9 status paths
        tdre_in = 1'b1; cts = 1'b1; #1;
        chk(tdre_out == 1'b0, "R8 cts high blocks tdre", int'(tdre_out), 0);
        chk(rd_data[0] == 1'b1, "R9 read bit0 shows cts high", int'(rd_data[0]), 1);
        cts = 1'b0; #1;
        chk(tdre_out == 1'b1, "R8 cts low passes tdre", int'(tdre_out), 1);
        chk(rd_data[0] == 1'b0, "R9 read bit0 shows cts low", int'(rd_data[0]), 0);
        @(negedge clk);

        // R2 R3 R4 R6: first bit_en after write, small codes, all combos
        for (int p = 0; p < 2; p++)
            for (int c = 0; c < 3; c++)
                for (int r = 0; r < 2; r++) begin
                    do_write(cfg(p, c, r, 0));
                    first_pulse(1'b1, (p ? 30 : 10) * (1 << c) * (r ? 64 : 16), "R4 R6 bit interval");
                end

        // R2 R3: larger codes, sampling interval
        for (int p = 0; p < 2; p++)
            for (int c = 3; c < 7; c++) begin
                do_write(cfg(p, c, 0, 0));
                first_pulse(1'b0, (p ? 30 : 10) * (1 << c), "R2 R3 samp interval");
            end

        // R9 stored field readback
        do_write(cfg(1, 5, 1, 1));
        chk(rd_data[7:1] == 7'b0011101, "R9 stored fields read back", int'(rd_data[7:1]), 7'b0011101);

        // R6 R7 R10: write lands in the cycle a bit pulse is due
        do_write(cfg(0, 1, 0, 0));
        first_pulse(1'b1, 320, "R4 bit interval before collision");
        chk(bit_en && samp_en, "R6 R10 pulse present in write cycle", int'({bit_en, samp_en}), 3);
        do_write(cfg(0, 1, 0, 1));
        chk(parity_odd == 1'b1, "R7 parity odd after write", int'(parity_odd), 1);
        first_pulse(1'b1, 320, "R6 R7 full period after collision write");
        @(negedge clk);
        chk(!bit_en && !samp_en, "R10 pulse lasts one cycle", int'({bit_en, samp_en}), 0);

        // large combination, full bit period
        do_write(cfg(1, 4, 1, 0));
        chk(parity_odd == 1'b0, "R7 parity even after write", int'(parity_odd), 0);
        first_pulse(1'b1, 30 * 16 * 64, "R2 R3 R4 bit interval large");

        // R5 external clock, prescaler setting irrelevant
        do_write(cfg(0, 7, 0, 0));
        ext_run(20, 20, 1, "R5 ext pre10");
        do_write(cfg(1, 7, 0, 0));
        ext_run(16, 16, 1, "R5 ext pre30");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule